// File: doc/BRIEF.md
# Prescaled JTAG Bit Shifter

This block moves up to one byte across a JTAG port, one bit per generated TCK period. A single start pulse loads a data byte, a bit count, a shift mode and a prescaler value; the block then walks through the requested number of bit periods. In each period it presents a data bit while TCK is low, raises TCK, samples TDO, and holds TCK high before moving on. A prescaler value sets how long TCK stays low and how long it stays high. When the last period ends, the block lowers TCK and pulses `done`.

Three kinds of transfer share one instance. The outgoing byte can be driven onto TDI, or onto TMS to walk the TAP state machine. A capture-only transfer drives neither line and only collects TDO. In every mode, the bits leave from the most significant end of one internal register, and the captured TDO bits enter at its least significant end. After the transfer that register is the result byte. A host sequencer that decodes commands and splits them into bytes sits above this block.

Top module: `tap_bit_serializer`

## Requirements
- R1: After reset and whenever no transfer is running, `tck` and `tdi` are 0, `done` is 0, and `tms` follows the `tms_level` input.
- R2: With prescaler value P captured at start, `tck` is low for exactly 1 + (P+1)/2 clock cycles in every bit period (integer division). The first period begins in the cycle after the start edge.
- R3: In every bit period, `tck` is high for exactly 1 + P/2 clock cycles, so a period lasts 2 + P cycles. `tdi` does not change while `tck` is high.
- R4: `bit_count` holds the number of bits minus one: 0 gives one bit and 7 gives eight bits. Bits leave MSB first, so bit period k presents `data_in[DATA_W-1-k]`. In mode 0 that bit drives `tdi`.
- R5: In mode 0 (`mode` = 2'b00, TDI shift), `tms` follows `tms_level` throughout the transfer.
- R6: In mode 1 (`mode` = 2'b01, TMS shift), the period's data bit drives `tms` and `tdi` is held at 0.
- R7: In modes 2'b10 and 2'b11 (capture only), `tdi` is 0, `tms` follows `tms_level`, and TDO is still captured.
- R8: TDO is sampled on the clock edge at which `tck` goes high. For an N-bit transfer, the result is the input byte shifted left by N, with the TDO bit from period k placed at bit N-1-k.
- R9: `done` is high for exactly one cycle, the cycle after the last high phase ends, with `tck` low. `result` holds its value from that cycle until the next accepted start.
- R10: A start pulse while a transfer runs is ignored. Changes on `data_in`, `bit_count`, `mode` and `prescale` during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (taken only when idle) |
| data_in | input | DATA_W | Byte to shift out |
| bit_count | input | $clog2(DATA_W) | Number of bits minus one |
| mode | input | 2 | 00 TDI shift, 01 TMS shift, 1x capture only |
| tms_level | input | 1 | Static TMS level when TMS is not being shifted |
| prescale | input | PRESCALE_W | Sets low and high phase lengths |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Generated test clock |
| tdi | output | 1 | Test data to the target |
| tms | output | 1 | Test mode select |
| result | output | DATA_W | Shifted register, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with DATA_W = 8 and PRESCALE_W = 4. This makes the full prescaler range 0 to 15 reachable, including the zero case where both phases collapse to their single base cycle and the odd values where the low phase is one cycle longer than the high phase. The bench uses 8-bit data so that one-bit, partial and full-byte transfers all occur. With a full byte, the original data is shifted entirely out of the result. It also covers every mode encoding, a start taken in the done cycle, and inputs changed during a running transfer.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_t;

   localparam logic [1:0] MODE_TDI = 2'b00;
   localparam logic [1:0] MODE_TMS = 2'b01;

endpackage

// File: rtl/tbs_prescale_split.sv
module tbs_prescale_split #(
   parameter int PRESCALE_W = 4
) (
   input  logic [PRESCALE_W-1:0] prescale,
   output logic [PRESCALE_W-1:0] low_len,
   output logic [PRESCALE_W-1:0] high_len
);

   localparam int EXT_W = PRESCALE_W + 1;

   logic [EXT_W-1:0] rounded;

   always_comb begin
      rounded  = ({1'b0, prescale} + EXT_W'(1)) >> 1;
      low_len  = rounded[PRESCALE_W-1:0];
      high_len = prescale >> 1;
   end

endmodule

// File: rtl/tbs_phase_ctrl.sv
module tbs_phase_ctrl
   import tbs_pkg::*;
#(
   parameter int PRESCALE_W = 4,
   parameter int CNT_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [CNT_W-1:0]      bit_count,
   input  logic [PRESCALE_W-1:0] low_len,
   input  logic [PRESCALE_W-1:0] high_len,
   output phase_t                phase,
   output logic                  load,
   output logic                  capture,
   output logic                  advance,
   output logic                  done
);

   logic [PRESCALE_W-1:0] timer;
   logic [PRESCALE_W-1:0] low_q;
   logic [PRESCALE_W-1:0] high_q;
   logic [CNT_W-1:0]      bits_left;
   logic                  timer_zero;

   always_comb begin
      timer_zero = (timer == '0);
      load       = (phase == PH_IDLE) && start;
      capture    = (phase == PH_LOW)  && timer_zero;
      advance    = (phase == PH_HIGH) && timer_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         timer     <= '0;
         low_q     <= '0;
         high_q    <= '0;
         bits_left <= '0;
         done      <= 1'b0;
      end else begin
         done <= advance && (bits_left == '0);
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase     <= PH_LOW;
                  timer     <= low_len;
                  low_q     <= low_len;
                  high_q    <= high_len;
                  bits_left <= bit_count;
               end
            end
            PH_LOW: begin
               if (timer_zero) begin
                  phase <= PH_HIGH;
                  timer <= high_q;
               end else begin
                  timer <= timer - 1'b1;
               end
            end
            PH_HIGH: begin
               if (timer_zero) begin
                  if (bits_left == '0) begin
                     phase <= PH_IDLE;
                  end else begin
                     phase     <= PH_LOW;
                     timer     <= low_q;
                     bits_left <= bits_left - 1'b1;
                  end
               end else begin
                  timer <= timer - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tbs_shift_reg.sv
module tbs_shift_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              capture,
   input  logic              advance,
   input  logic [DATA_W-1:0] data_in,
   input  logic              tdo,
   output logic              msb,
   output logic [DATA_W-1:0] value
);

   logic [DATA_W-1:0] sr;
   logic              sampled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         sampled <= 1'b0;
      end else begin
         if (load) begin
            sr <= data_in;
         end else if (advance) begin
            sr <= {sr[DATA_W-2:0], sampled};
         end
         if (capture) begin
            sampled <= tdo;
         end
      end
   end

   assign msb   = sr[DATA_W-1];
   assign value = sr;

endmodule

// File: rtl/tbs_pin_drive.sv
module tbs_pin_drive
   import tbs_pkg::*;
(
   input  phase_t     phase,
   input  logic [1:0] mode_q,
   input  logic       bit_out,
   input  logic       tms_level,
   output logic       tck,
   output logic       tdi,
   output logic       tms
);

   logic active;

   always_comb begin
      active = (phase != PH_IDLE);
      tck    = (phase == PH_HIGH);
      tdi    = active && (mode_q == MODE_TDI) && bit_out;
      tms    = (active && (mode_q == MODE_TMS)) ? bit_out : tms_level;
   end

endmodule

// File: rtl/tap_bit_serializer.sv
module tap_bit_serializer
   import tbs_pkg::*;
#(
   parameter  int DATA_W     = 8,
   parameter  int PRESCALE_W = 4,
   localparam int CNT_W      = $clog2(DATA_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [DATA_W-1:0]     data_in,
   input  logic [CNT_W-1:0]      bit_count,
   input  logic [1:0]            mode,
   input  logic                  tms_level,
   input  logic [PRESCALE_W-1:0] prescale,
   input  logic                  tdo,
   output logic                  tck,
   output logic                  tdi,
   output logic                  tms,
   output logic [DATA_W-1:0]     result,
   output logic                  done
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (PRESCALE_W < 1) begin : g_bad_prescale
         $error("PRESCALE_W must be at least 1");
      end
   endgenerate

   phase_t                phase;
   logic                  load;
   logic                  capture;
   logic                  advance;
   logic                  bit_out;
   logic [1:0]            mode_q;
   logic [PRESCALE_W-1:0] low_len;
   logic [PRESCALE_W-1:0] high_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_TDI;
      end else if (load) begin
         mode_q <= mode;
      end
   end

   tbs_prescale_split #(
      .PRESCALE_W (PRESCALE_W)
   ) i_split (
      .prescale (prescale),
      .low_len  (low_len),
      .high_len (high_len)
   );

   tbs_phase_ctrl #(
      .PRESCALE_W (PRESCALE_W),
      .CNT_W      (CNT_W)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .bit_count (bit_count),
      .low_len   (low_len),
      .high_len  (high_len),
      .phase     (phase),
      .load      (load),
      .capture   (capture),
      .advance   (advance),
      .done      (done)
   );

   tbs_shift_reg #(
      .DATA_W (DATA_W)
   ) i_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .capture (capture),
      .advance (advance),
      .data_in (data_in),
      .tdo     (tdo),
      .msb     (bit_out),
      .value   (result)
   );

   tbs_pin_drive i_pins (
      .phase     (phase),
      .mode_q    (mode_q),
      .bit_out   (bit_out),
      .tms_level (tms_level),
      .tck       (tck),
      .tdi       (tdi),
      .tms       (tms)
   );

endmodule

// File: rtl/tbs_checker.sv
module tbs_checker
   import tbs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       tms_level,
   input logic       tck,
   input logic       tdi,
   input logic       tms,
   input logic       done,
   input phase_t     phase,
   input logic [1:0] mode_q
);

   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> (!tck && !tdi && (tms == tms_level)));

   assert_tdi_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tck && $past(tck)) |-> $stable(tdi));

   assert_tms_mode_tdi_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_IDLE) && (mode_q == MODE_TMS)) |-> !tdi);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_tck_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tck);

   assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_IDLE) && start) |=> $stable(mode_q));

endmodule

bind tap_bit_serializer tbs_checker i_tbs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .tms_level (tms_level),
   .tck       (tck),
   .tdi       (tdi),
   .tms       (tms),
   .done      (done),
   .phase     (phase),
   .mode_q    (mode_q)
);

// File: tb/test_tap_bit_serializer.sv
`timescale 1ns/1ps
module test_tap_bit_serializer;

   localparam int W   = 8;
   localparam int PSW = 4;
   localparam int CW  = $clog2(W);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   data_in = '0;
   logic [CW-1:0]  bit_count = '0;
   logic [1:0]     mode = 2'b00;
   logic           tms_level = 1'b0;
   logic [PSW-1:0] prescale = '0;
   logic           tdo = 1'b0;
   logic           tck, tdi, tms, done;
   logic [W-1:0]   result;

   always #2 clk = ~clk;

   tap_bit_serializer #(.DATA_W(W), .PRESCALE_W(PSW)) i_tap_bit_serializer (
      .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
      .bit_count(bit_count), .mode(mode), .tms_level(tms_level),
      .prescale(prescale), .tdo(tdo), .tck(tck), .tdi(tdi), .tms(tms),
      .result(result), .done(done)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit chk_en   = 1'b0;
   bit finished = 1'b0;
   string tag_ovr = "";
   logic [W-1:0] next_pat = '0;

   // behavioural reference model
   bit           m_busy = 1'b0;
   bit           m_done = 1'b0;
   bit           m_res_valid = 1'b0;
   int           m_k, m_n, m_per, m_s;
   logic [W-1:0] m_data, m_pat, m_res;
   logic [1:0]   m_mode;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 1'b0;
         m_done = 1'b0;
         m_res_valid = 1'b0;
      end else if (m_busy) begin
         m_k = m_k + 1;
         if (m_k == m_n * m_per) begin
            m_busy = 1'b0;
            m_done = 1'b1;
            m_res = m_data << m_n;
            for (int b = 0; b < m_n; b++) m_res[m_n-1-b] = m_pat[b];
            m_res_valid = 1'b1;
         end
      end else begin
         m_done = 1'b0;
         if (start) begin
            m_busy = 1'b1;
            m_k    = 0;
            m_data = data_in;
            m_n    = int'(bit_count) + 1;
            m_mode = mode;
            m_s    = (int'(prescale) + 1) / 2;
            m_per  = 2 + int'(prescale);
            m_pat  = next_pat;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      string t;
      t = (tag_ovr != "") ? tag_ovr : tag;
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", t, what, act, exp, cyc);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // per-cycle comparison and target-side TDO drive
   always @(negedge clk) begin
      int  b, w;
      bit  e_tck, e_tdi, e_tms, bitv;
      cyc++;
      if (rst_n && chk_en) begin
         if (m_busy) begin
            b = m_k / m_per;
            w = m_k % m_per;
            e_tck = (w >= 1 + m_s);
            bitv  = m_data[W-1-b];
            e_tdi = (m_mode == 2'b00) ? bitv : 1'b0;
            e_tms = (m_mode == 2'b01) ? bitv : tms_level;
            chk(tck === e_tck, e_tck ? "R3" : "R2", "tck", int'(tck), int'(e_tck));
            chk(tdi === e_tdi, (m_mode == 2'b00) ? "R4" : (m_mode == 2'b01) ? "R6" : "R7",
                "tdi", int'(tdi), int'(e_tdi));
            chk(tms === e_tms, (m_mode == 2'b00) ? "R5" : (m_mode == 2'b01) ? "R6" : "R7",
                "tms", int'(tms), int'(e_tms));
            chk(done === 1'b0, "R9", "done", int'(done), 0);
         end else begin
            chk(tck === 1'b0, "R1", "tck idle", int'(tck), 0);
            chk(tdi === 1'b0, "R1", "tdi idle", int'(tdi), 0);
            chk(tms === tms_level, "R1", "tms idle", int'(tms), int'(tms_level));
            chk(done === m_done, "R9", "done", int'(done), int'(m_done));
            if (m_res_valid)
               chk(result === m_res, m_done ? "R8" : "R9", "result", int'(result), int'(m_res));
         end
      end
      tdo <= m_busy ? m_pat[m_k / m_per] : 1'b0;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired, actual=running expected=finished");
         report();
      end
   end

   task automatic run(input logic [W-1:0] d, input int cnt, input logic [1:0] md,
                      input int ps, input bit tl, input logic [W-1:0] pat, input bit b2b);
      if (!b2b) @(negedge clk);
      #1;
      data_in   = d;
      bit_count = CW'(cnt);
      mode      = md;
      prescale  = PSW'(ps);
      tms_level = tl;
      next_pat  = pat;
      start     = 1'b1;
      @(negedge clk);
      #1;
      start = 1'b0;
      while (m_busy) @(negedge clk);
   endtask

   initial begin
      int ps_list[6] = '{0, 1, 2, 3, 6, 15};
      int cnt_list[3] = '{0, 3, 7};
      int seed = 7;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tck === 1'b0, "R1", "tck in reset", int'(tck), 0);
      chk(tdi === 1'b0, "R1", "tdi in reset", int'(tdi), 0);
      chk(done === 1'b0, "R1", "done in reset", int'(done), 0);
      chk(tms === tms_level, "R1", "tms in reset", int'(tms), int'(tms_level));
      #1 rst_n = 1'b1;
      chk_en = 1'b1;
      repeat (2) @(negedge clk);

      for (int md = 0; md < 4; md++) begin
         for (int pi = 0; pi < 6; pi++) begin
            for (int ci = 0; ci < 3; ci++) begin
               seed = seed * 1103515245 + 12345;
               run(W'(seed >> 8), cnt_list[ci], 2'(md), ps_list[pi],
                   seed[20], W'(seed >> 16), 1'b0);
               repeat (2) @(negedge clk);
            end
         end
      end

      // start accepted in the done cycle (R9 boundary)
      run(8'hA5, 7, 2'b00, 1, 1'b0, 8'h3C, 1'b0);
      run(8'h5A, 4, 2'b01, 2, 1'b1, 8'hC3, 1'b1);
      repeat (3) @(negedge clk);

      // R10: start and input changes during a running transfer
      tag_ovr = "R10";
      @(negedge clk);
      #1;
      data_in = 8'h96; bit_count = 3'd5; mode = 2'b00; prescale = 4'd3;
      next_pat = 8'h2D; start = 1'b1;
      @(negedge clk);
      #1 start = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      data_in = 8'h0F; bit_count = 3'd1; mode = 2'b01; prescale = 4'd9; start = 1'b1;
      repeat (3) @(negedge clk);
      #1 start = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      tag_ovr = "";

      report();
   end

endmodule